// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This block runs a platform's power-up sequence, from a button request to the release of the processor core reset. A raw push-button level is synchronised and debounced. A qualified press drives the active-low suspend line low. The supply-enable line follows it low and turns the supply on. The sequencer then waits for power-good from the supply. It enables the clock generator, waits for the clock to report stable, and releases the active-low peripheral-bus reset. After a minimum hold it releases the active-low core reset.

Each waiting phase is bounded by its own timeout. On expiry the sequencer parks in a fault state that turns the supply off again. A fresh qualified press leaves that state. If power-good drops once the clock has been enabled, the clock enable and both resets fall together. The sequencer then waits for power-good again with the supply still requested. The power-good and clock-stable inputs are asynchronous and pass through the same two-stage synchroniser as the button.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, susp_n_o=1, supply_en_n_o=1, clk_en_o=0, bus_rst_n_o=0 and core_rst_n_o=0, and these hold until a qualified press.
- R2: Take the first clock edge that samples a new high button level as edge 1. The button must stay high for DEBOUNCE_CYC cycles, and susp_n_o then falls on edge DEBOUNCE_CYC+2. A high pulse shorter than DEBOUNCE_CYC cycles changes no output.
- R3: supply_en_n_o carries the same level as susp_n_o at all times, so the supply runs only while suspend is asserted low.
- R4: clk_en_o never rises before power-good. When power-good rises during the supply wait, clk_en_o rises on edge 3, counted as in R2. If power-good is already high, clk_en_o rises one edge after the supply wait is entered.
- R5: bus_rst_n_o is released only while clk_en_o is high. If clock-stable rises after clk_en_o, the release comes on edge 3. If clock-stable is already high, the release comes one edge after clk_en_o rises.
- R6: core_rst_n_o rises only in a cycle following one in which synchronised power-good, synchronised clock-stable and bus_rst_n_o=1 all held.
- R7: core_rst_n_o rises exactly CORE_HOLD cycles after bus_rst_n_o rises, provided power-good and clock-stable stay high.
- R8: power-good may fall while clk_en_o=1. Then clk_en_o, bus_rst_n_o and core_rst_n_o all go low on edge 3 with susp_n_o still low. When power-good returns, the sequence resumes from the supply wait.
- R9: If power-good is not seen within PG_TIMEOUT cycles of entering the supply wait, susp_n_o and supply_en_n_o return high on that edge and the fault state is entered.
- R10: If clock-stable is not seen within CLK_TIMEOUT cycles of clk_en_o rising, all outputs return to their R1 values and the fault state is entered.
- R11: In the fault state the outputs equal the R1 values. A qualified press restarts the sequence with the R2 timing.
- R12: Button activity after the sequence has started changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| button_i | input | 1 | Raw power-button level, active high, asynchronous |
| pwr_good_i | input | 1 | Power-good from the supply, asynchronous |
| clk_stable_i | input | 1 | Clock generator reports a stable output, asynchronous |
| susp_n_o | output | 1 | Suspend, active low |
| supply_en_n_o | output | 1 | Supply enable, active low |
| clk_en_o | output | 1 | Clock generator enable |
| bus_rst_n_o | output | 1 | Peripheral-bus reset, active low |
| core_rst_n_o | output | 1 | Processor core reset, active low |

## Verification
Every result has a fixed latency, counted from the first edge that samples the stimulus:
- The suspend fall comes DEBOUNCE_CYC+2 edges after a press.
- A power-good or clock-stable change acts after 3 edges, because of the two synchroniser stages and the state register.
- The core release follows the bus release by CORE_HOLD edges.
- A timeout fires exactly PG_TIMEOUT or CLK_TIMEOUT edges after its phase begins.

The driver applies inputs half a cycle away from the active edge. For each stimulus it queues the output vector together with the exact cycle number the vector is due. The monitor compares every output change against the head of that queue at the opposite clock edge, so an early, late or missing transition is reported. Direct checks after glitches and button presses mid-run confirm that the outputs held still.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF      = 3'd0,
    SEQ_WAIT_PG  = 3'd1,
    SEQ_CLK_WAIT = 3'd2,
    SEQ_BUS_HOLD = 3'd3,
    SEQ_RUN      = 3'd4,
    SEQ_FAULT    = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic susp_n;
    logic clk_en;
    logic bus_rst_n;
    logic core_rst_n;
  } seq_out_t;

  // True once a counter that started at zero has covered 'lim' cycles.
  function automatic logic limit_reached(input int unsigned count, input int unsigned lim);
    return (count + 1) >= lim;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int unsigned maxval);
    int w;
    w = $clog2(maxval + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Output levels per state; suspend is the master line for the supply.
  function automatic seq_out_t decode_outputs(input seq_state_e st);
    seq_out_t o;
    o.susp_n     = 1'b1;
    o.clk_en     = 1'b0;
    o.bus_rst_n  = 1'b0;
    o.core_rst_n = 1'b0;
    case (st)
      SEQ_WAIT_PG:  o.susp_n = 1'b0;
      SEQ_CLK_WAIT: begin o.susp_n = 1'b0; o.clk_en = 1'b1; end
      SEQ_BUS_HOLD: begin o.susp_n = 1'b0; o.clk_en = 1'b1; o.bus_rst_n = 1'b1; end
      SEQ_RUN:      begin o.susp_n = 1'b0; o.clk_en = 1'b1; o.bus_rst_n = 1'b1;
                          o.core_rst_n = 1'b1; end
      default:      ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/seq_sync.sv
`timescale 1ns/1ps
module seq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[g] <= '0;
        else         chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[g] <= '0;
        else         chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
`timescale 1ns/1ps
module btn_debounce
  import pwr_seq_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic press_o
);
  localparam int CW = cnt_width(DEBOUNCE_CYC);

  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          differs;
  logic          settle;

  assign differs = (level_i != stable_q);
  assign settle  = differs && limit_reached(32'(cnt_q), DEBOUNCE_CYC);
  assign press_o = settle && level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (settle) begin
      stable_q <= level_i;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  if (DEBOUNCE_CYC > 1) begin : g_chk
    AST_PRESS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      press_o |-> $past(level_i)); // R2
  end
endmodule

// File: rtl/phase_timer.sv
`timescale 1ns/1ps
module phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_o <= '0;
    else if (clear_i)         count_o <= '0;
    else if (count_o != '1)   count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int PG_TIMEOUT  = 20,
  parameter int CLK_TIMEOUT = 16,
  parameter int CORE_HOLD   = 8,
  parameter int TW          = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          press_i,
  input  logic          pg_i,
  input  logic          ck_i,
  input  logic [TW-1:0] tmr_cnt_i,
  output logic          tmr_clear_o,
  output seq_out_t      outs_o
);
  seq_state_e state_q, state_d;

  // Named internal events.
  logic powered, pg_lost, pg_wait_expired, clk_wait_expired, hold_done, got_pg, got_clk;

  assign powered          = (state_q == SEQ_CLK_WAIT) || (state_q == SEQ_BUS_HOLD) ||
                            (state_q == SEQ_RUN);
  assign pg_lost          = powered && !pg_i;
  assign got_pg           = (state_q == SEQ_WAIT_PG) && pg_i;
  assign got_clk          = (state_q == SEQ_CLK_WAIT) && pg_i && ck_i;
  assign pg_wait_expired  = (state_q == SEQ_WAIT_PG) && !pg_i &&
                            limit_reached(32'(tmr_cnt_i), PG_TIMEOUT);
  assign clk_wait_expired = (state_q == SEQ_CLK_WAIT) && pg_i && !ck_i &&
                            limit_reached(32'(tmr_cnt_i), CLK_TIMEOUT);
  assign hold_done        = (state_q == SEQ_BUS_HOLD) && pg_i && ck_i &&
                            limit_reached(32'(tmr_cnt_i), CORE_HOLD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_OFF, SEQ_FAULT: if (press_i) state_d = SEQ_WAIT_PG;
      SEQ_WAIT_PG: begin
        if (got_pg)               state_d = SEQ_CLK_WAIT;
        else if (pg_wait_expired) state_d = SEQ_FAULT;
      end
      SEQ_CLK_WAIT: begin
        if (pg_lost)               state_d = SEQ_WAIT_PG;
        else if (got_clk)          state_d = SEQ_BUS_HOLD;
        else if (clk_wait_expired) state_d = SEQ_FAULT;
      end
      SEQ_BUS_HOLD: begin
        if (pg_lost)        state_d = SEQ_WAIT_PG;
        else if (hold_done) state_d = SEQ_RUN;
      end
      SEQ_RUN: if (pg_lost) state_d = SEQ_WAIT_PG;
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_OFF;
    else         state_q <= state_d;
  end

  assign tmr_clear_o = (state_d != state_q);
  assign outs_o      = decode_outputs(state_q);

  // Age of the bus-reset release, kept for the hold check.
  logic [TW-1:0] bus_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bus_age_q <= '0;
    else if (!outs_o.bus_rst_n) bus_age_q <= '0;
    else if (bus_age_q != '1)   bus_age_q <= bus_age_q + 1'b1;
  end

  logic susp_n_w, clk_en_w, bus_w, core_w;
  assign susp_n_w = outs_o.susp_n;
  assign clk_en_w = outs_o.clk_en;
  assign bus_w    = outs_o.bus_rst_n;
  assign core_w   = outs_o.core_rst_n;

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_n_w && !press_i) |=> susp_n_w); // R1
  AST_CLK_AFTER_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_w) |-> $past(pg_i)); // R4
  AST_BUS_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_w) |-> ($past(ck_i) && clk_en_w)); // R5
  AST_CORE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_w) |-> $past(pg_i && ck_i && bus_w)); // R6
  AST_CORE_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_w) |-> (32'(bus_age_q) >= CORE_HOLD)); // R7
  AST_PG_LOSS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_w && !pg_i) |=> (!clk_en_w && !bus_w && !core_w && !susp_n_w)); // R8
  AST_PG_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wait_expired |=> susp_n_w); // R9
  AST_CLK_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wait_expired |=> (susp_n_w && !clk_en_w)); // R10
  AST_RUN_IGNORES_BTN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_w && pg_i) |=> core_w); // R12
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 4,
  parameter int PG_TIMEOUT   = 20,
  parameter int CLK_TIMEOUT  = 16,
  parameter int CORE_HOLD    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic button_i,
  input  logic pwr_good_i,
  input  logic clk_stable_i,
  output logic susp_n_o,
  output logic supply_en_n_o,
  output logic clk_en_o,
  output logic bus_rst_n_o,
  output logic core_rst_n_o
);
  localparam int MAX_LIM = max3(PG_TIMEOUT, CLK_TIMEOUT, CORE_HOLD);
  localparam int TW      = cnt_width(MAX_LIM);

  logic [2:0]    raw_in, synced;
  logic          btn_s, pg_s, ck_s, press;
  logic          tmr_clear;
  logic [TW-1:0] tmr_cnt;
  seq_out_t      outs;
  logic          suspend_active;

  assign raw_in = {button_i, pwr_good_i, clk_stable_i};

  seq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(synced));

  assign btn_s = synced[2];
  assign pg_s  = synced[1];
  assign ck_s  = synced[0];

  btn_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(btn_s), .press_o(press));

  phase_timer #(.CW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(tmr_clear), .count_o(tmr_cnt));

  pwr_seq_fsm #(
    .PG_TIMEOUT(PG_TIMEOUT), .CLK_TIMEOUT(CLK_TIMEOUT),
    .CORE_HOLD(CORE_HOLD), .TW(TW)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .press_i(press), .pg_i(pg_s), .ck_i(ck_s),
    .tmr_cnt_i(tmr_cnt), .tmr_clear_o(tmr_clear), .outs_o(outs));

  // Supply enable is the inverse of an asserted (low) suspend line.
  assign suspend_active = ~outs.susp_n;
  assign susp_n_o       = outs.susp_n;
  assign supply_en_n_o  = ~suspend_active;
  assign clk_en_o       = outs.clk_en;
  assign bus_rst_n_o    = outs.bus_rst_n;
  assign core_rst_n_o   = outs.core_rst_n;
endmodule

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int PGT  = 20;
  localparam int CKT  = 16;
  localparam int HOLD = 8;
  // Latencies derived from the requirements (edge counts after the driving negedge).
  localparam int LAT_PRESS = DEB + 2;  // R2
  localparam int LAT_SYNC  = 3;        // R4, R5, R8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic button = 1'b0, pg = 1'b0, ck = 1'b0;
  logic susp_n, sup_n, clk_en, bus_n, core_n;

  pwr_seq_ctrl #(.DEBOUNCE_CYC(DEB), .PG_TIMEOUT(PGT), .CLK_TIMEOUT(CKT),
                 .CORE_HOLD(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .button_i(button), .pwr_good_i(pg),
    .clk_stable_i(ck), .susp_n_o(susp_n), .supply_en_n_o(sup_n), .clk_en_o(clk_en),
    .bus_rst_n_o(bus_n), .core_rst_n_o(core_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output vector: {susp_n, supply_en_n, clk_en, bus_rst_n, core_rst_n}
  logic [4:0] outs;
  assign outs = {susp_n, sup_n, clk_en, bus_n, core_n};
  localparam logic [4:0] V_OFF = 5'b11000, V_SUP = 5'b00000, V_CLK = 5'b00100,
                         V_BUS = 5'b00110, V_RUN = 5'b00111;

  typedef struct { int unsigned at; logic [4:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t e;
  int checks = 0, fails = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [4:0] prev_outs = V_OFF;

  task automatic push(input int unsigned at, input logic [4:0] v, input string tag);
    exp_t x;
    x.at = at; x.val = v; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic wait_cyc(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic check_now(input string tag, input logic [4:0] expv);
    checks++;
    if (outs !== expv) begin
      fails++;
      $display("FAIL %s: outputs %b, expected %b", tag, outs, expv);
    end
  endtask

  // Monitor: every output change must match the head of the queue, in value and cycle.
  always @(negedge clk) begin
    if (mon_en && (outs !== prev_outs)) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R12 unexpected change at cycle %0d: outputs %b, expected %b",
                 cyc, outs, prev_outs);
      end else begin
        e = exp_q.pop_front();
        if (outs !== e.val || cyc != e.at) begin
          fails++;
          $display("FAIL %s: cycle %0d outputs %b, expected cycle %0d outputs %b",
                   e.tag, cyc, outs, e.at, e.val);
        end
      end
    end
    if (mon_en) prev_outs = outs;
  end

  initial begin
    int unsigned n;
    repeat (3) @(negedge clk);
    check_now("R1 reset state", V_OFF);
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R2: a 2-cycle glitch is ignored.
    n = cyc + 2;
    wait_cyc(n); button = 1'b1;
    wait_cyc(n + 2); button = 1'b0;
    wait_cyc(n + 14);
    check_now("R2 glitch ignored", V_OFF);
    check_now("R1 off holds", V_OFF);

    // Normal power-up: R2 R3 R4 R5 R6 R7
    n = cyc + 1;
    wait_cyc(n); button = 1'b1;
    push(n + LAT_PRESS, V_SUP, "R2/R3 suspend and supply low");
    wait_cyc(n + 8); button = 1'b0;
    push(n + 11 + LAT_SYNC, V_CLK, "R4 clock enable after power-good");
    wait_cyc(n + 11); pg = 1'b1;
    push(n + 17 + LAT_SYNC, V_BUS, "R5 bus reset release");
    push(n + 17 + LAT_SYNC + HOLD, V_RUN, "R6/R7 core release after hold");
    wait_cyc(n + 17); ck = 1'b1;
    wait_cyc(n + 40);
    check_now("R3 supply tracks suspend", V_RUN);

    // R12: press while running changes nothing.
    n = cyc + 1;
    wait_cyc(n); button = 1'b1;
    wait_cyc(n + 8); button = 1'b0;
    wait_cyc(n + 20);
    check_now("R12 press ignored while running", V_RUN);

    // R8: power-good loss in run, then recovery.
    n = cyc + 1;
    push(n + LAT_SYNC, V_SUP, "R8 resets reasserted");
    push(n + 10 + LAT_SYNC, V_CLK, "R8 clock re-enabled");
    push(n + 10 + LAT_SYNC + 1, V_BUS, "R5 bus release with clock already stable");
    push(n + 10 + LAT_SYNC + 1 + HOLD, V_RUN, "R7 core release after recovery");
    wait_cyc(n); pg = 1'b0;
    wait_cyc(n + 10); pg = 1'b1;
    wait_cyc(n + 30);

    // R9: power-good lost for good -> timeout to fault.
    n = cyc + 1;
    push(n + LAT_SYNC, V_SUP, "R8 resets reasserted");
    push(n + LAT_SYNC + PGT, V_OFF, "R9 power-good timeout");
    wait_cyc(n); pg = 1'b0; ck = 1'b0;
    wait_cyc(n + 30);
    check_now("R11 fault outputs", V_OFF);

    // R11 restart from fault, R10 clock timeout.
    n = cyc + 1;
    push(n + LAT_PRESS, V_SUP, "R11 restart from fault");
    push(n + 11 + LAT_SYNC, V_CLK, "R4 clock enable after power-good");
    push(n + 11 + LAT_SYNC + CKT, V_OFF, "R10 clock-stable timeout");
    wait_cyc(n); button = 1'b1;
    wait_cyc(n + 8); button = 1'b0;
    wait_cyc(n + 11); pg = 1'b1;
    wait_cyc(n + 40);
    check_now("R10 fault outputs", V_OFF);

    // Restart with power-good already present; loss during bus hold; recovery.
    n = cyc + 1;
    push(n + LAT_PRESS, V_SUP, "R11 restart from fault");
    push(n + LAT_PRESS + 1, V_CLK, "R4 power-good already present");
    push(n + 10 + LAT_SYNC, V_BUS, "R5 bus reset release");
    push(n + 15 + LAT_SYNC, V_SUP, "R8 loss during hold");
    push(n + 20 + LAT_SYNC, V_CLK, "R8 clock re-enabled");
    push(n + 20 + LAT_SYNC + 1, V_BUS, "R5 bus release again");
    push(n + 20 + LAT_SYNC + 1 + HOLD, V_RUN, "R6/R7 core release");
    wait_cyc(n); button = 1'b1;
    wait_cyc(n + 8); button = 1'b0;
    wait_cyc(n + 10); ck = 1'b1;
    wait_cyc(n + 15); pg = 1'b0;
    wait_cyc(n + 20); pg = 1'b1;
    wait_cyc(n + 45);
    check_now("R6 final run state", V_RUN);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d transitions missing, expected 0", exp_q[0].tag, exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule